// File: doc/BRIEF.md
# Bus Access Protection Checker

This block sits beside the processor's bus and decides, for every request, whether it must be refused with a data abort. A request carries an address, a size (byte, halfword or word), a read/write flag and a user/supervisor flag. The checker decodes the address against the system memory map and applies a set of rules: address range, mapped region, ROM write protection, privilege, hardware byte access and word alignment. When a request fails one or more rules, the abort output rises in the same cycle. The code of the highest-priority failing rule is stored in a read-only status word on the next clock edge.

A second path watches requests from three DMA-side masters: a general DMA engine, a page copy/fill engine and a sprite engine. A master that touches the protected system area, or that goes past the end of video memory, sets a sticky violation bit of its own. The bit stays set until a synchronous clear.

Both status words are read through a small combinational read port.

Top module: `bus_guard`

## Requirements
- R1: A supervisor request with a valid size and alignment does not abort when its address is in a mapped region. The mapped regions are 0x0000000–0x01FFFFF (DRAM), 0x0200000–0x02FFFFF (VRAM), 0x3000000–0x30FFFFF (ROM, reads only), 0x3140000–0x315FFFF (NVRAM), 0x3200000–0x32FFFFF (page engine) and 0x3300000–0x34FFFFF (the two hardware register blocks). Size encoding is 0 = byte, 1 = halfword, 2 = word.
- R2: Any request with an address at or above 0x4000000 aborts with reason 7.
- R3: A request below 0x4000000 that lies in no mapped region aborts with reason 10.
- R4: A write into the ROM region aborts with reason 1. Reads of the ROM region are allowed.
- R5: A user-mode request (reqUser = 1) to either hardware register block aborts with reason 3.
- R6: A user-mode request below 0x10000 aborts with reason 4. A supervisor request there, or a user request at 0x10000, does not abort.
- R7: A byte request to the hardware register range (0x3300000–0x34FFFFF) aborts with reason 9. A halfword request there is allowed.
- R8: A word request whose address bits [1:0] are not zero aborts with reason 12. Unaligned byte and halfword requests are not refused by this rule.
- R9: When several rules fail, the stored reason follows this priority, highest first: 7, 10, 1, 3, 4, 9, 12.
- R10: abortOut is combinational and is high only while reqValid is high. The reason word resets to 0. It loads the code on the clock edge that ends an aborting request, and it is otherwise unchanged.
- R11: A DMA request sets violation bit m when its address is below 0x10000, and bit m+3 when its address is at or above 0x300000. The master code m is 0 = general DMA, 1 = page engine, 2 = sprite engine. Master code 3 sets nothing.
- R12: Violation bits are sticky and reset to 0. dmaClear empties them on the next edge and wins over a set in the same cycle.
- R13: With rdSel = 0, rdData returns the reason in bits [3:0]. With rdSel = 1, it returns the violation bits in bits [5:0]. All other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | CPU request present |
| reqAddr | input | 32 | CPU request byte address |
| reqSize | input | 2 | 0 byte, 1 halfword, 2 word |
| reqWrite | input | 1 | 1 for a write |
| reqUser | input | 1 | 1 for user mode, 0 for supervisor |
| abortOut | output | 1 | Data abort for the current request |
| dmaValid | input | 1 | DMA-side request present |
| dmaMaster | input | 2 | Requesting master: 0 DMA, 1 page, 2 sprite |
| dmaAddr | input | 32 | DMA-side byte address |
| dmaClear | input | 1 | Synchronous clear of violation bits |
| rdSel | input | 1 | 0 reason word, 1 violation word |
| rdData | output | 32 | Selected status word |

## Verification
The assertions check these rules on every cycle:
- no abort without a request;
- an out-of-range or user hardware request always aborts;
- an aligned supervisor DRAM word read never aborts;
- the reason word moves only on a latch strobe;
- violation bits never drop except on a clear, and a clear empties them;
- the nonexistent fourth master sets nothing.

Only the bench scenarios show the exact reason code for each rule and the priority between overlapping rules. They also show the region boundaries and the per-master bit positions. In addition, they show that the reason survives non-aborting and invalid requests.

// File: rtl/bus_guard_pkg.sv
package bus_guard_pkg;

  localparam int CODE_W      = 4;
  localparam int NUM_MASTERS = 3;
  localparam int VIOL_W      = 2 * NUM_MASTERS;
  localparam int SEL_W       = 2;
  localparam int MAP_BITS    = 26;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  localparam logic [31:0] DRAM_LO  = 32'h000_0000;
  localparam logic [31:0] DRAM_HI  = 32'h020_0000;
  localparam logic [31:0] VRAM_HI  = 32'h030_0000;
  localparam logic [31:0] ROM_LO   = 32'h300_0000;
  localparam logic [31:0] ROM_HI   = 32'h310_0000;
  localparam logic [31:0] NVRAM_LO = 32'h314_0000;
  localparam logic [31:0] NVRAM_HI = 32'h316_0000;
  localparam logic [31:0] PAGE_LO  = 32'h320_0000;
  localparam logic [31:0] HW_LO    = 32'h330_0000;
  localparam logic [31:0] HW_HI    = 32'h350_0000;
  localparam logic [31:0] SYS_HI   = 32'h001_0000;

  localparam logic [CODE_W-1:0] RSN_ROM_WRITE = 4'd1;
  localparam logic [CODE_W-1:0] RSN_USER_HW   = 4'd3;
  localparam logic [CODE_W-1:0] RSN_USER_SYS  = 4'd4;
  localparam logic [CODE_W-1:0] RSN_RANGE     = 4'd7;
  localparam logic [CODE_W-1:0] RSN_BYTE_HW   = 4'd9;
  localparam logic [CODE_W-1:0] RSN_UNMAPPED  = 4'd10;
  localparam logic [CODE_W-1:0] RSN_UNALIGNED = 4'd12;

  typedef struct packed {
    logic              latchReason;
    logic [CODE_W-1:0] reasonCode;
    logic [VIOL_W-1:0] dmaSet;
    logic              dmaClr;
  } guard_strb_t;

endpackage

// File: rtl/bus_guard_ctrl.sv
module bus_guard_ctrl
  import bus_guard_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic              reqWrite,
  input  logic              reqUser,
  input  logic              dmaValid,
  input  logic [SEL_W-1:0]  dmaMaster,
  input  logic [ADDR_W-1:0] dmaAddr,
  input  logic              dmaClear,
  output logic              abortOut,
  output guard_strb_t       strb
);

  function automatic logic inWin(input logic [ADDR_W-1:0] x,
                                 input logic [ADDR_W-1:0] lo,
                                 input logic [ADDR_W-1:0] hi);
    return (x >= lo) && (x < hi);
  endfunction

  logic inDram, inVram, inRom, inNvram, inPage, inHw, inSys;
  logic fRange, fUnmapped, fRom, fUserHw, fUserSys, fByteHw, fUnal;
  logic anyFail;
  logic [CODE_W-1:0] code;

  assign inDram  = inWin(reqAddr, ADDR_W'(DRAM_LO),  ADDR_W'(DRAM_HI));
  assign inVram  = inWin(reqAddr, ADDR_W'(DRAM_HI),  ADDR_W'(VRAM_HI));
  assign inRom   = inWin(reqAddr, ADDR_W'(ROM_LO),   ADDR_W'(ROM_HI));
  assign inNvram = inWin(reqAddr, ADDR_W'(NVRAM_LO), ADDR_W'(NVRAM_HI));
  assign inPage  = inWin(reqAddr, ADDR_W'(PAGE_LO),  ADDR_W'(HW_LO));
  assign inHw    = inWin(reqAddr, ADDR_W'(HW_LO),    ADDR_W'(HW_HI));
  assign inSys   = reqAddr < ADDR_W'(SYS_HI);

  assign fRange    = |reqAddr[ADDR_W-1:MAP_BITS];
  assign fUnmapped = !fRange && !(inDram || inVram || inRom || inNvram || inPage || inHw);
  assign fRom      = inRom && reqWrite;
  assign fUserHw   = inHw && reqUser;
  assign fUserSys  = inSys && reqUser;
  assign fByteHw   = inHw && (reqSize == SZ_BYTE);
  assign fUnal     = (reqSize == SZ_WORD) && (reqAddr[1:0] != 2'b00);

  assign anyFail = fRange | fUnmapped | fRom | fUserHw | fUserSys | fByteHw | fUnal;

  always_comb begin
    if (fRange)         code = RSN_RANGE;
    else if (fUnmapped) code = RSN_UNMAPPED;
    else if (fRom)      code = RSN_ROM_WRITE;
    else if (fUserHw)   code = RSN_USER_HW;
    else if (fUserSys)  code = RSN_USER_SYS;
    else if (fByteHw)   code = RSN_BYTE_HW;
    else                code = RSN_UNALIGNED;
  end

  assign abortOut         = reqValid && anyFail;
  assign strb.latchReason = abortOut;
  assign strb.reasonCode  = code;
  assign strb.dmaClr      = dmaClear;

  logic dmaSys, dmaOver;
  assign dmaSys  = dmaAddr < ADDR_W'(SYS_HI);
  assign dmaOver = dmaAddr >= ADDR_W'(VRAM_HI);

  for (genvar m = 0; m < NUM_MASTERS; m++) begin : gMaster
    logic hit;
    assign hit = dmaValid && (dmaMaster == SEL_W'(m));
    assign strb.dmaSet[m]               = hit && dmaSys;
    assign strb.dmaSet[m + NUM_MASTERS] = hit && dmaOver;
  end

  // R10: no abort without a request
  assert_no_abort_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> !abortOut);

  // R2: out-of-range addresses always abort
  assert_range_aborts_R2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (reqAddr >= ADDR_W'(32'h400_0000))) |-> abortOut);

  // R5: user access to hardware always aborts
  assert_user_hw_aborts_R5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqUser && (reqAddr >= ADDR_W'(HW_LO)) && (reqAddr < ADDR_W'(HW_HI)))
      |-> abortOut);

  // R1: aligned supervisor word read of DRAM never aborts
  assert_dram_ok_R1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqUser && !reqWrite && (reqSize == SZ_WORD) &&
     (reqAddr[1:0] == 2'b00) && (reqAddr < ADDR_W'(DRAM_HI))) |-> !abortOut);

  // R11: master code 3 sets no violation
  assert_no_fourth_master_R11: assert property (@(posedge clk) disable iff (!rstN)
    (dmaMaster == SEL_W'(3)) |-> (strb.dmaSet == '0));

endmodule

// File: rtl/bus_guard_dp.sv
module bus_guard_dp
  import bus_guard_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  guard_strb_t       strb,
  input  logic              rdSel,
  output logic [DATA_W-1:0] rdData
);

  logic [CODE_W-1:0] reasonQ;
  logic [VIOL_W-1:0] stickyQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reasonQ <= '0;
    end else if (strb.latchReason) begin
      reasonQ <= strb.reasonCode;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stickyQ <= '0;
    end else if (strb.dmaClr) begin
      stickyQ <= '0;
    end else begin
      stickyQ <= stickyQ | strb.dmaSet;
    end
  end

  always_comb begin
    rdData = '0;
    if (rdSel) rdData[VIOL_W-1:0] = stickyQ;
    else       rdData[CODE_W-1:0] = reasonQ;
  end

  // R10: reason only moves on a latch strobe
  assert_reason_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !strb.latchReason |=> $stable(reasonQ));

  // R12: sticky bits never drop without a clear
  assert_sticky_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    !strb.dmaClr |=> ((stickyQ & $past(stickyQ)) == $past(stickyQ)));

  // R12: a clear empties all bits
  assert_clear_empties_R12: assert property (@(posedge clk) disable iff (!rstN)
    strb.dmaClr |=> (stickyQ == '0));

endmodule

// File: rtl/bus_guard.sv
module bus_guard
  import bus_guard_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic              reqWrite,
  input  logic              reqUser,
  output logic              abortOut,
  input  logic              dmaValid,
  input  logic [1:0]        dmaMaster,
  input  logic [ADDR_W-1:0] dmaAddr,
  input  logic              dmaClear,
  input  logic              rdSel,
  output logic [DATA_W-1:0] rdData
);

  guard_strb_t strb;

  bus_guard_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqAddr(reqAddr), .reqSize(reqSize),
    .reqWrite(reqWrite), .reqUser(reqUser),
    .dmaValid(dmaValid), .dmaMaster(dmaMaster), .dmaAddr(dmaAddr),
    .dmaClear(dmaClear),
    .abortOut(abortOut), .strb(strb)
  );

  bus_guard_dp #(.DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .rdSel(rdSel), .rdData(rdData)
  );

endmodule

// File: tb/bus_guard_test.sv
`timescale 1ns/100ps
module bus_guard_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [1:0]  reqSize = '0;
  logic        reqWrite = 1'b0;
  logic        reqUser = 1'b0;
  logic        abortOut;
  logic        dmaValid = 1'b0;
  logic [1:0]  dmaMaster = '0;
  logic [31:0] dmaAddr = '0;
  logic        dmaClear = 1'b0;
  logic        rdSel = 1'b0;
  logic [31:0] rdData;

  bus_guard uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqSize(reqSize), .reqWrite(reqWrite), .reqUser(reqUser),
    .abortOut(abortOut), .dmaValid(dmaValid), .dmaMaster(dmaMaster),
    .dmaAddr(dmaAddr), .dmaClear(dmaClear), .rdSel(rdSel), .rdData(rdData)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    int     code;
    longint stamp;
    string  tag;
  } item_t;

  item_t  sb[$];
  longint cycleCnt = 0;
  int     total = 0;
  int     bad = 0;
  int     lastExp = 0;
  bit     done = 0;

  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected reason once its latching edge has passed
  always @(negedge clk) begin
    if (sb.size() > 0 && sb[0].stamp < cycleCnt) begin
      item_t it;
      it = sb.pop_front();
      check(rdData == 32'(it.code), {it.tag, " reason"}, rdData, it.code);
    end
  end

  // driver: expCode < 0 means no abort expected
  task automatic cpuReq(input logic [31:0] a, input logic [1:0] sz, input logic wr,
                        input logic usr, input int expCode, input string tag);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqSize = sz; reqWrite = wr; reqUser = usr;
    #1;
    check(abortOut == (expCode >= 0), {tag, " abort"}, abortOut, expCode >= 0);
    if (expCode >= 0) lastExp = expCode;
    sb.push_back('{lastExp, cycleCnt, tag});
  endtask

  task automatic dmaReq(input logic [1:0] m, input logic [31:0] a, input logic clr,
                        input int exp, input string tag);
    @(negedge clk);
    dmaValid = 1'b1; dmaMaster = m; dmaAddr = a; dmaClear = clr;
    @(negedge clk);
    dmaValid = 1'b0; dmaClear = 1'b0;
    #1;
    check(rdData == 32'(exp), tag, rdData, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(rdData == 0, "R10 reset reason", rdData, 0);
    rdSel = 1'b1; #1;
    check(rdData == 0, "R12 reset violations", rdData, 0);
    rdSel = 1'b0;
    rstN = 1'b1;

    // R1 mapped regions, supervisor
    cpuReq(32'h000_0000, 2, 0, 0, -1, "R1 dram word");
    cpuReq(32'h020_0100, 2, 1, 0, -1, "R1 vram write");
    cpuReq(32'h300_0003, 0, 0, 0, -1, "R1 rom byte read");
    cpuReq(32'h314_0000, 2, 1, 0, -1, "R1 nvram");
    cpuReq(32'h32F_FFFC, 2, 1, 0, -1, "R1 page top");
    cpuReq(32'h330_0000, 2, 0, 0, -1, "R1 hw block a");
    cpuReq(32'h34F_FFFC, 2, 1, 0, -1, "R1 hw block b top");
    // R2
    cpuReq(32'h400_0000, 2, 0, 0, 7, "R2 range start");
    cpuReq(32'hFFFF_FFFC, 2, 0, 0, 7, "R2 top");
    // R3
    cpuReq(32'h030_0000, 2, 0, 0, 10, "R3 above vram");
    cpuReq(32'h310_0000, 2, 0, 0, 10, "R3 rom gap");
    cpuReq(32'h316_0000, 2, 0, 0, 10, "R3 nvram gap");
    cpuReq(32'h350_0000, 2, 0, 0, 10, "R3 above hw");
    cpuReq(32'h3FF_FFFC, 2, 0, 0, 10, "R3 last word");
    // R4
    cpuReq(32'h300_0000, 2, 1, 0, 1, "R4 rom write");
    // R5
    cpuReq(32'h330_0000, 2, 0, 1, 3, "R5 user hw a");
    cpuReq(32'h340_0004, 2, 1, 1, 3, "R5 user hw b");
    // R6
    cpuReq(32'h000_FFFC, 2, 0, 1, 4, "R6 user sys top");
    cpuReq(32'h001_0000, 2, 0, 1, -1, "R6 user above sys");
    cpuReq(32'h000_0010, 2, 1, 0, -1, "R6 supervisor sys");
    // R7
    cpuReq(32'h330_0001, 0, 0, 0, 9, "R7 byte hw");
    cpuReq(32'h340_0002, 1, 0, 0, -1, "R7 half hw");
    // R8
    cpuReq(32'h020_0001, 2, 0, 0, 12, "R8 unaligned word");
    cpuReq(32'h020_0001, 1, 0, 0, -1, "R8 unaligned half");
    cpuReq(32'h000_1003, 0, 1, 0, -1, "R8 unaligned byte");
    // R9 priority
    cpuReq(32'h400_0001, 0, 1, 1, 7, "R9 range over all");
    cpuReq(32'h310_0002, 2, 1, 1, 10, "R9 unmapped over unaligned");
    cpuReq(32'h300_0002, 2, 1, 1, 1, "R9 rom over unaligned");
    cpuReq(32'h340_0001, 0, 0, 1, 3, "R9 user hw over byte");
    cpuReq(32'h000_0002, 2, 0, 1, 4, "R9 user sys over unaligned");
    cpuReq(32'h330_0003, 0, 0, 0, 9, "R9 byte hw");
    // R10 invalid request is ignored
    @(negedge clk);
    reqValid = 1'b0; reqAddr = 32'h400_0000; reqUser = 1'b1;
    #1;
    check(abortOut == 1'b0, "R10 idle abort", abortOut, 0);
    sb.push_back('{lastExp, cycleCnt, "R10 idle keeps"});
    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R10 scoreboard drained", sb.size(), 0);

    // R11 / R12 / R13 violation word
    rdSel = 1'b1;
    dmaReq(0, 32'h0000_FFFF, 0, 32'h01, "R11 dma sys");
    dmaReq(1, 32'h0030_0000, 0, 32'h11, "R11 page over vram");
    dmaReq(2, 32'h002F_FFFF, 0, 32'h11, "R11 sprite vram top ok");
    dmaReq(2, 32'h0000_8000, 0, 32'h15, "R11 sprite sys");
    dmaReq(3, 32'h0000_0000, 0, 32'h15, "R11 master3 ignored");
    dmaReq(0, 32'h0020_0000, 0, 32'h15, "R12 sticky kept");
    dmaReq(0, 32'h0000_0000, 1, 32'h00, "R12 clear wins");
    dmaReq(0, 32'h0050_0000, 0, 32'h08, "R11 dma over vram");
    dmaReq(1, 32'h0000_0100, 0, 32'h0A, "R11 page sys");
    dmaReq(2, 32'h0040_0000, 0, 32'h2A, "R13 sprite over vram");
    rdSel = 1'b0; #1;
    check(rdData == 32'd9, "R13 reason select", rdData, 9);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule